// File: doc/BRIEF.md
# Error-Correcting Dual-Clock Word Memory

This block is a synchronous memory with separate write and read clocks. Each stored word is 72 bits wide: 64 data bits and 8 check bits. The check bits form a single-error-correcting, double-error-detecting code. The code is a 7-bit Hamming code over the data, plus one overall parity bit. On a read, the block corrects a single flipped bit and raises a single-error flag. When two bits have flipped, it raises a double-error flag and leaves the data uncorrected.

A two-bit mode input chooses whether the write path encodes, whether the read path decodes, both, or neither. This lets the memory do three extra jobs. It can act as a check-bit generator for plain 64-bit words. It can accept an arbitrary 72-bit word, so a fault can be planted in memory. It can return stored words untouched. To inject a fault, read a word raw, invert one or two of its bits, and write all 72 bits back with encoding switched off. A parameter inserts one more register stage on the read outputs.

Top module: `ecc_ram`

## Requirements
- R1: In mode 00 (encode and decode), a word written and later read back returns the same 64 data bits with both error flags low.
- R2: The check bits are defined as follows. Data bit j, counting from bit 0 upward, takes the j-th position in ascending order among 1..71, skipping the powers of two. Check bit i (0..6) is the XOR of every data bit whose position has bit i set. Check bit 7 is the XOR of all 64 data bits and check bits 0..6.
- R3: A write in mode 00 or 01 loads the computed check bits onto `enc_chk` at that write-clock edge. Writes in modes 10 and 11, and cycles without a write, leave `enc_chk` unchanged.
- R4: In mode 01 (encode only), a read returns the stored 72 bits unchanged on `rd_data` and `rd_chk`, with both flags low. `rd_chk` never carries a corrected value in any mode.
- R5: In mode 10 (decode only) and in mode 11, a write stores `wr_data` and `wr_chk` exactly as supplied.
- R6: A decoded read (mode 00 or 10) of a word with one flipped data bit returns the corrected data, with `sbit_err` high and `dbit_err` low.
- R7: A decoded read of a word with one flipped check bit raises `sbit_err` and returns the data unchanged.
- R8: A decoded read of a word with two flipped bits raises `dbit_err`, keeps `sbit_err` low, and returns the stored data uncorrected.
- R9: Both flags are low in every output cycle that does not result from a read.
- R10: In mode 11 (bypass), a read returns the stored 72 bits raw and both flags stay low, even when the word is faulty.
- R11: With `OUT_REG` = 0, outputs are valid after the read-clock edge that samples `rd_en`. With `OUT_REG` = 1, data, check bits and flags appear exactly one read-clock edge later.
- R12: While `rst` is high, `rd_data`, `rd_chk`, both flags and `enc_chk` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, applied in both clock domains |
| mode | input | 2 | 00 encode+decode, 01 encode only, 10 decode only, 11 bypass |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 64 | Write data |
| wr_chk | input | 8 | Check bits stored as given when encoding is off |
| enc_chk | output | 8 | Check bits computed by the last encoding write |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 64 | Read data, corrected when decoding |
| rd_chk | output | 8 | Stored check bits, raw |
| sbit_err | output | 1 | Corrected single-bit error |
| dbit_err | output | 1 | Detected double-bit error |

## Verification
The bench plants faulty words through the decode-only write path and then reads them in several modes. If a correction mask is placed wrongly, a single data flip comes back with the wrong bit inverted. If the decoder confuses check-bit faults with data faults, a check-bit flip corrupts the data. A wrong single/double decision shows up as the wrong flag when bits flip in the overall parity bit or in a check-plus-data pair. Two instances, one per output-register setting, are sampled in the same cycles, which exposes a missing or extra pipeline stage. Idle cycles after each read would show flags that are not tied to read-valid or to the decoding modes.

// File: rtl/ecc_ram_pkg.sv
package ecc_ram_pkg;

  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int HAM_W  = CHK_W - 1;
  localparam int WORD_W = DATA_W + CHK_W;

  typedef enum logic [1:0] {
    MODE_FULL = 2'b00,
    MODE_ENC  = 2'b01,
    MODE_DEC  = 2'b10,
    MODE_RAW  = 2'b11
  } ecc_mode_e;

  function automatic logic is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // Hamming position (1..WORD_W-1, powers of two skipped) of data bit j
  function automatic logic [HAM_W-1:0] data_pos(input int j);
    logic [HAM_W-1:0] r;
    int cnt;
    r = '0;
    cnt = 0;
    for (int p = 1; p < WORD_W; p++) begin
      if (!is_pow2(p)) begin
        if (cnt == j) r = HAM_W'(p);
        cnt++;
      end
    end
    return r;
  endfunction

  // Data bits covered by Hamming check bit i
  function automatic logic [DATA_W-1:0] ham_mask(input int i);
    logic [DATA_W-1:0] m;
    for (int j = 0; j < DATA_W; j++) begin
      logic [HAM_W-1:0] q;
      q = data_pos(j);
      m[j] = q[i];
    end
    return m;
  endfunction

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
  import ecc_ram_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);

  logic [HAM_W-1:0] ham;

  for (genvar i = 0; i < HAM_W; i++) begin : g_ham
    localparam logic [DATA_W-1:0] MASK = ham_mask(i);
    assign ham[i] = ^(data & MASK);
  end

  assign chk = {(^data) ^ (^ham), ham};

endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
  import ecc_ram_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic [DATA_W-1:0] data_fix,
  output logic              sbe,
  output logic              dbe
);

  logic [DATA_W-1:0] d;
  logic [CHK_W-1:0]  c;
  logic [CHK_W-1:0]  rc;
  logic [HAM_W-1:0]  syn;
  logic              par;
  logic              syn_ok;
  logic [DATA_W-1:0] flip;

  assign d = word[DATA_W-1:0];
  assign c = word[WORD_W-1:DATA_W];

  ecc_enc u_enc (.data(d), .chk(rc));

  assign syn    = rc[HAM_W-1:0] ^ c[HAM_W-1:0];
  // parity over all stored bits, rebuilt from the recomputed overall bit
  assign par    = rc[CHK_W-1] ^ c[CHK_W-1] ^ (^syn);
  assign syn_ok = (int'(syn) < WORD_W);

  assign sbe = par & syn_ok;
  assign dbe = (!par && (syn != '0)) || (par && !syn_ok);

  for (genvar j = 0; j < DATA_W; j++) begin : g_fix
    localparam logic [HAM_W-1:0] POS = data_pos(j);
    assign flip[j] = sbe & (syn == POS);
  end

  assign data_fix = d ^ flip;

endmodule

// File: rtl/ecc_ram_mem.sv
module ecc_ram_mem #(
  parameter int ADDR_W = 6,
  parameter int WIDTH  = 72
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [WIDTH-1:0]  wd,
  input  logic              re,
  input  logic [ADDR_W-1:0] ra,
  output logic [WIDTH-1:0]  rq
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge rd_clk) begin
    if (rst)     rq <= '0;
    else if (re) rq <= mem[ra];
  end

endmodule

// File: rtl/ecc_ram.sv
module ecc_ram
  import ecc_ram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter bit OUT_REG = 1'b0
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CHK_W-1:0]  wr_chk,
  output logic [CHK_W-1:0]  enc_chk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CHK_W-1:0]  rd_chk,
  output logic              sbit_err,
  output logic              dbit_err
);

  // mode bit 1 set: write path stores raw; mode bit 0 set: read path raw
  logic              do_enc;
  logic              do_dec;
  logic [CHK_W-1:0]  calc_chk;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] rd_word;
  logic              vld_q;
  logic              dec_q;
  logic [DATA_W-1:0] fix_data;
  logic              raw_sbe;
  logic              raw_dbe;
  logic [DATA_W-1:0] s0_data;
  logic              s0_sbe;
  logic              s0_dbe;

  assign do_enc = ~mode[1];
  assign do_dec = ~mode[0];

  ecc_enc u_enc (.data(wr_data), .chk(calc_chk));

  assign wr_word = {do_enc ? calc_chk : wr_chk, wr_data};

  always_ff @(posedge wr_clk) begin
    if (rst)                  enc_chk <= '0;
    else if (wr_en && do_enc) enc_chk <= calc_chk;
  end

  ecc_ram_mem #(.ADDR_W(ADDR_W), .WIDTH(WORD_W)) u_mem (
    .wr_clk (wr_clk),
    .rd_clk (rd_clk),
    .rst    (rst),
    .we     (wr_en),
    .wa     (wr_addr),
    .wd     (wr_word),
    .re     (rd_en),
    .ra     (rd_addr),
    .rq     (rd_word)
  );

  always_ff @(posedge rd_clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      dec_q <= 1'b0;
    end else begin
      vld_q <= rd_en;
      if (rd_en) dec_q <= do_dec;
    end
  end

  ecc_dec u_dec (
    .word     (rd_word),
    .data_fix (fix_data),
    .sbe      (raw_sbe),
    .dbe      (raw_dbe)
  );

  assign s0_data = dec_q ? fix_data : rd_word[DATA_W-1:0];
  assign s0_sbe  = vld_q & dec_q & raw_sbe;
  assign s0_dbe  = vld_q & dec_q & raw_dbe;

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge rd_clk) begin
      if (rst) begin
        rd_data  <= '0;
        rd_chk   <= '0;
        sbit_err <= 1'b0;
        dbit_err <= 1'b0;
      end else begin
        rd_data  <= s0_data;
        rd_chk   <= rd_word[WORD_W-1:DATA_W];
        sbit_err <= s0_sbe;
        dbit_err <= s0_dbe;
      end
    end
  end else begin : g_direct
    assign rd_data  = s0_data;
    assign rd_chk   = rd_word[WORD_W-1:DATA_W];
    assign sbit_err = s0_sbe;
    assign dbit_err = s0_dbe;
  end

endmodule

// File: rtl/ecc_ram_chk.sv
module ecc_ram_chk #(
  parameter bit OUT_REG = 1'b0
) (
  input logic        wr_clk,
  input logic        rd_clk,
  input logic        rst,
  input logic [1:0]  mode,
  input logic        wr_en,
  input logic        rd_en,
  input logic [63:0] rd_data,
  input logic [7:0]  enc_chk,
  input logic        sbit_err,
  input logic        dbit_err
);

  localparam int LAT = OUT_REG ? 2 : 1;

  logic [1:0] rd_hist;
  logic [1:0] dec_hist;

  always_ff @(posedge rd_clk) begin
    if (rst) begin
      rd_hist  <= '0;
      dec_hist <= '0;
    end else begin
      rd_hist  <= {rd_hist[0], rd_en};
      dec_hist <= {dec_hist[0], rd_en & ~mode[0]};
    end
  end

  // R6 R8
  flags_exclusive_chk: assert property (@(posedge rd_clk) disable iff (rst)
    !(sbit_err && dbit_err));

  // R9
  flag_needs_read_chk: assert property (@(posedge rd_clk) disable iff (rst)
    (sbit_err || dbit_err) |-> rd_hist[LAT-1]);

  // R10
  raw_read_quiet_chk: assert property (@(posedge rd_clk) disable iff (rst)
    (sbit_err || dbit_err) |-> dec_hist[LAT-1]);

  // R12
  reset_clear_chk: assert property (@(posedge rd_clk) disable iff (rst)
    $fell(rst) |-> (!sbit_err && !dbit_err && rd_data == '0));

  // R3
  enc_hold_chk: assert property (@(posedge wr_clk) disable iff (rst)
    !$past(wr_en) |-> $stable(enc_chk));

endmodule

bind ecc_ram ecc_ram_chk #(.OUT_REG(OUT_REG)) u_chk (
  .wr_clk   (wr_clk),
  .rd_clk   (rd_clk),
  .rst      (rst),
  .mode     (mode),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .enc_chk  (enc_chk),
  .sbit_err (sbit_err),
  .dbit_err (dbit_err)
);

// File: tb/sim_ecc_ram.sv
module sim_ecc_ram;
  import ecc_ram_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = MODE_FULL;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_chk = '0;
  logic        rd_en = 1'b0;
  logic [5:0]  rd_addr = '0;

  logic [7:0]  enc0, enc1;
  logic [63:0] d0, d1;
  logic [7:0]  c0, c1;
  logic        s0, s1, e0, e1;

  int checks = 0;
  int fails  = 0;

  // captured results of the last read
  logic [63:0] r0_d, r1_d;
  logic [7:0]  r0_c, r1_c;
  logic        r0_s, r0_e, r1_s, r1_e, early1_s, early1_e, idle0_s, idle0_e;

  always #2.5 clk = ~clk;

  ecc_ram #(.ADDR_W(6), .OUT_REG(1'b0)) u0 (
    .wr_clk(clk), .rd_clk(clk), .rst(rst), .mode(mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_chk(wr_chk),
    .enc_chk(enc0), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(d0), .rd_chk(c0), .sbit_err(s0), .dbit_err(e0));

  ecc_ram #(.ADDR_W(6), .OUT_REG(1'b1)) u1 (
    .wr_clk(clk), .rd_clk(clk), .rst(rst), .mode(mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_chk(wr_chk),
    .enc_chk(enc1), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(d1), .rd_chk(c1), .sbit_err(s1), .dbit_err(e1));

  // check bits built from the code definition, position by position
  function automatic logic [7:0] ref_chk(input logic [63:0] d);
    logic [71:0] cw;
    logic [7:0]  c;
    int k;
    cw = '0;
    k = 0;
    for (int p = 1; p < 72; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[k];
        k++;
      end
    end
    c = '0;
    for (int i = 0; i < 7; i++)
      for (int p = 1; p < 72; p++)
        if (((p >> i) & 1) == 1) c[i] = c[i] ^ cw[p];
    c[7] = (^d) ^ (^c[6:0]);
    return c;
  endfunction

  task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] m, input logic [5:0] a,
                          input logic [63:0] d, input logic [7:0] c);
    @(negedge clk);
    mode = m; wr_addr = a; wr_data = d; wr_chk = c; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] m, input logic [5:0] a);
    @(negedge clk);
    mode = m; rd_addr = a; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    r0_d = d0; r0_c = c0; r0_s = s0; r0_e = e0;
    early1_s = s1; early1_e = e1;
    @(posedge clk);
    @(negedge clk);
    r1_d = d1; r1_c = c1; r1_s = s1; r1_e = e1;
    idle0_s = s0; idle0_e = e0;
  endtask

  localparam int NV = 6;
  localparam logic [63:0] VEC [NV] = '{
    64'h0000_0000_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF,
    64'h0123_4567_89AB_CDEF,
    64'h8000_0000_0000_0001,
    64'hA5A5_5A5A_F00F_0FF0,
    64'h0000_0001_0000_0000
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [63:0] dd;
    logic [7:0]  cc;
    logic [63:0] fd;
    logic [7:0]  fc;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: outputs cleared during reset
    check("R12 u0 data/chk", {c0, d0}, 72'h0);
    check("R12 u1 data/chk", {c1, d1}, 72'h0);
    check("R12 flags/enc", {s0, e0, s1, e1, enc0}, 12'h0);
    rst = 1'b0;

    // R1 R2: table walk in mode 00
    for (int k = 0; k < NV; k++) begin
      do_write(MODE_FULL, 6'(k), VEC[k], 8'h5A);
      check("R2 enc_chk after full write", 72'(enc0), 72'(ref_chk(VEC[k])));
      do_read(MODE_FULL, 6'(k));
      check("R1 round trip data", 72'(r0_d), 72'(VEC[k]));
      check("R2 stored check bits", 72'(r0_c), 72'(ref_chk(VEC[k])));
      check("R1 flags low", {r0_s, r0_e}, 72'h0);
      check("R11 registered copy", {r1_c, r1_d}, {ref_chk(VEC[k]), VEC[k]});
    end

    // R3 R4: encode-only write and raw read-back
    dd = 64'hDEAD_BEEF_0BAD_F00D;
    cc = ref_chk(dd);
    do_write(MODE_ENC, 6'd10, dd, 8'h00);
    check("R3 enc_chk on write edge", 72'(enc0), 72'(cc));
    do_read(MODE_ENC, 6'd10);
    check("R4 encode-only raw word", {r0_c, r0_d}, {cc, dd});
    check("R4 encode-only flags", {r0_s, r0_e}, 72'h0);

    // R3: raw-mode writes leave enc_chk alone
    do_write(MODE_DEC, 6'd20, 64'h1111, 8'hFF);
    check("R3 enc_chk held on decode-only write", 72'(enc0), 72'(cc));
    do_write(MODE_RAW, 6'd21, 64'h2222, 8'h0F);
    check("R3 enc_chk held on bypass write", 72'(enc1), 72'(cc));

    // R6: inject a single data error by read-modify-write
    fd = r0_d ^ (64'h1 << 37);
    fc = r0_c;
    do_write(MODE_DEC, 6'd11, fd, fc);
    do_read(MODE_RAW, 6'd11);
    check("R5 decode-only stores as given", {r0_c, r0_d}, {fc, fd});
    check("R10 bypass flags on bad word", {r0_s, r0_e}, 72'h0);
    do_read(MODE_FULL, 6'd11);
    check("R6 corrected data", 72'(r0_d), 72'(dd));
    check("R6 flags", {r0_s, r0_e}, 72'h2);
    check("R9 idle cycle flags", {idle0_s, idle0_e}, 72'h0);
    check("R11 u1 not yet flagged", {early1_s, early1_e}, 72'h0);
    check("R11 u1 one cycle later", {r1_s, r1_e, r1_d}, {2'b10, dd});
    do_read(MODE_DEC, 6'd11);
    check("R6 decode-only read corrects", {r0_s, r0_e, r0_d}, {2'b10, dd});

    // R7: flip a Hamming check bit, then the overall parity bit
    do_write(MODE_DEC, 6'd12, dd, cc ^ 8'h08);
    do_read(MODE_FULL, 6'd12);
    check("R7 check-bit error data", 72'(r0_d), 72'(dd));
    check("R7 check-bit error flags", {r0_s, r0_e}, 72'h2);
    check("R4 rd_chk raw under decode", 72'(r0_c), 72'(cc ^ 8'h08));
    do_write(MODE_DEC, 6'd13, dd, cc ^ 8'h80);
    do_read(MODE_FULL, 6'd13);
    check("R7 parity-bit error", {r0_s, r0_e, r0_d}, {2'b10, dd});

    // R8: two data bits, then one data and one check bit
    fd = dd ^ 64'h0000_0100_0000_0001;
    do_write(MODE_DEC, 6'd14, fd, cc);
    do_read(MODE_FULL, 6'd14);
    check("R8 double data error", {r0_s, r0_e, r0_d}, {2'b01, fd});
    fd = dd ^ 64'h0000_0000_0010_0000;
    do_write(MODE_DEC, 6'd15, fd, cc ^ 8'h02);
    do_read(MODE_DEC, 6'd15);
    check("R8 data+check double", {r0_s, r0_e, r0_d}, {2'b01, fd});
    check("R11 u1 double one cycle later", {early1_e, r1_e}, 72'h1);

    // R10: bypass read of a double-error word stays quiet
    do_read(MODE_RAW, 6'd15);
    check("R10 bypass raw word", {r0_c, r0_d}, {cc ^ 8'h02, fd});
    check("R10 bypass flags", {r0_s, r0_e, r1_s, r1_e}, 72'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule